// File: doc/BRIEF.md
# Indexed Clock Register Port

This block is the host-facing side of a real-time clock. It holds a store of configuration and time bytes, 128 of them by default, and reaches them through a two-location byte port. A write to the even location selects a byte. An access to the odd location then reads or writes the selected byte. Four bytes of the store are control and status registers with their own rules:

- **Control A (index 10):** its top bit is a busy flag that belongs to the timekeeper.
- **Control B (index 11):** holds the enable and mode bits.
- **Status C (index 12):** collects the event flags and is cleared when read.
- **Status D (index 13):** fixed.

The timekeeping and periodic logic sit outside this block. They read the control bytes from two export buses, set or clear the busy flag through strobes, and report periodic, alarm and update-ended events through three more strobes. When the halt bit in B is clear, a host write to one of the seven time bytes is also passed to the timekeeper as a one-cycle load strobe carrying the index and the data. The interrupt line follows the summary bit of the status byte.

Top module: `rtc_regfile_port`

## Requirements
- R1: A write to the even location (host_addr=0) stores the low 7 bits of the data as the index, and bit 7 is dropped. A read of the even location returns 0xFF.
- R2: A write to the odd location (host_addr=1) at any index other than 10 to 13 stores the byte. A later odd read at that index returns the byte on host_rdata one cycle after the read strobe.
- R3: Bit 7 of control A (the busy flag) cannot be changed by host writes, while bits 6:0 take the written value. tk_uip_clr clears the flag. tk_uip_set sets it only while B bit 7 (halt) is 0, and tk_uip_clr wins over tk_uip_set.
- R4: A write to B with data bit 7 = 1 clears A bit 7 and stores B with bit 4 (update-ended enable) forced to 0.
- R5: Host writes to C (index 12) and D (index 13) have no effect.
- R6: An event strobe sets its flag in C only when its enable in B is 1. The pairs are periodic (C bit 6, B bit 6), alarm (C bit 5, B bit 5) and update-ended (C bit 4, B bit 4). Setting any flag also sets C bit 7. irq_o equals C bit 7.
- R7: An odd read at index 12 returns C, then clears C and lowers irq_o. An event strobe in the same cycle is kept and is not lost.
- R8: After rst_n the control bytes are A=0x26, B=0x02, C=0x00 and D=0x80. irq_o is 0 and tk_load_o is 0.
- R9: A sys_reset pulse clears B bits 6, 5 and 3, clears C and lowers irq_o. The other bits of B, all of A and all stored bytes are kept.
- R10: An odd write at index 0, 2, 4, 6, 7, 8 or 9 while B bit 7 is 0 pulses tk_load_o for one cycle, with tk_idx_o and tk_data_o set to the index and data. No pulse occurs while B bit 7 is 1 or for any other index.
- R11: ctrl_a_o and ctrl_b_o always show the current A and B bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sys_reset | input | 1 | Soft reset strobe for enables and flags |
| host_addr | input | 1 | 0 selects the index location, 1 selects the data location |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data, valid the cycle after host_rd |
| tk_uip_set | input | 1 | Timekeeper sets the busy flag |
| tk_uip_clr | input | 1 | Timekeeper clears the busy flag |
| ev_periodic | input | 1 | Periodic event strobe |
| ev_alarm | input | 1 | Alarm match strobe |
| ev_update | input | 1 | Update-ended strobe |
| ctrl_a_o | output | 8 | Current control A byte |
| ctrl_b_o | output | 8 | Current control B byte |
| tk_load_o | output | 1 | Time byte load strobe to the timekeeper |
| tk_idx_o | output | IDX_W | Index of the loaded time byte |
| tk_data_o | output | 8 | Data of the loaded time byte |
| irq_o | output | 1 | Interrupt request |

## Verification
Every result of this block appears at the clock edge that samples the stimulus. This covers the read data for host_rdata, the new control bytes, the status flags behind irq_o, the clear-on-read and the tk_load_o pulse. The bench drives each strobe for exactly one cycle, starting from a falling edge, and samples one nanosecond after the next rising edge. That is the first instant the registered result is visible. The load strobe is checked at that same instant, because it has dropped again by the following edge. A concurrent read-and-event cycle is driven as one combined strobe, so the returned value and the surviving flag are sampled together.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
    localparam int BYTE_W = 8;

    // control byte indices: the timekeeper and host software decode these
    localparam int IDX_A = 10;
    localparam int IDX_B = 11;
    localparam int IDX_C = 12;
    localparam int IDX_D = 13;

    // control A
    localparam int A_BUSY = 7;
    // control B
    localparam int B_HALT   = 7;
    localparam int B_PER_EN = 6;
    localparam int B_ALM_EN = 5;
    localparam int B_UPD_EN = 4;
    localparam int B_SQW_EN = 3;
    // status C
    localparam int C_ANY = 7;
    localparam int C_PER = 6;
    localparam int C_ALM = 5;
    localparam int C_UPD = 4;

    localparam logic [BYTE_W-1:0] RST_A = 8'h26;
    localparam logic [BYTE_W-1:0] RST_B = 8'h02;
    localparam logic [BYTE_W-1:0] RST_C = 8'h00;
    localparam logic [BYTE_W-1:0] RST_D = 8'h80;

    typedef enum logic [1:0] {
        SEL_A = 2'd0,
        SEL_B = 2'd1,
        SEL_C = 2'd2,
        SEL_D = 2'd3
    } ctrl_sel_e;

    typedef struct packed {
        logic [BYTE_W-1:0] a;
        logic [BYTE_W-1:0] b;
        logic [BYTE_W-1:0] c;
        logic [BYTE_W-1:0] d;
    } ctrl_regs_t;

    // indices of seconds, minutes, hours, weekday, day, month, year
    function automatic logic is_time_idx(input int unsigned i);
        return (i == 0) || (i == 2) || (i == 4) || (i == 6) ||
               (i == 7) || (i == 8) || (i == 9);
    endfunction

    function automatic logic is_ctrl_idx(input int unsigned i);
        return (i >= IDX_A) && (i <= IDX_D);
    endfunction
endpackage

// File: rtl/rtcp_store.sv
module rtcp_store
    import rtcp_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BYTE_W-1:0] rd_byte
);
    logic [BYTE_W-1:0] bytes_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_byte
        logic [BYTE_W-1:0] byte_d;
        logic [BYTE_W-1:0] byte_q;

        always_comb begin
            byte_d = byte_q;
            if (wr_en && (wr_idx == IDX_W'(g))) begin
                byte_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else begin
                byte_q <= byte_d;
            end
        end

        assign bytes_q[g] = byte_q;
    end

    assign rd_byte = bytes_q[rd_idx];
endmodule

// File: rtl/rtcp_ctrl.sv
module rtcp_ctrl
    import rtcp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset,
    input  logic              wr_en,
    input  ctrl_sel_e         wr_sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              rd_c,
    input  logic              uip_set,
    input  logic              uip_clr,
    input  logic              ev_per,
    input  logic              ev_alm,
    input  logic              ev_upd,
    output ctrl_regs_t        regs,
    output logic              irq
);
    ctrl_regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;

        // busy flag owned by the timekeeper
        if (uip_clr) begin
            regs_d.a[A_BUSY] = 1'b0;
        end else if (uip_set && !regs_q.b[B_HALT]) begin
            regs_d.a[A_BUSY] = 1'b1;
        end

        if (wr_en) begin
            unique case (wr_sel)
                SEL_A: regs_d.a = {regs_d.a[A_BUSY], wdata[BYTE_W-2:0]};
                SEL_B: begin
                    regs_d.b = wdata;
                    if (wdata[B_HALT]) begin
                        regs_d.b[B_UPD_EN] = 1'b0;
                        regs_d.a[A_BUSY]   = 1'b0;
                    end
                end
                default: ;  // status bytes are not host writable
            endcase
        end

        // clear-on-read first, so a same-cycle event survives
        if (rd_c) begin
            regs_d.c = '0;
        end
        if (ev_per && regs_q.b[B_PER_EN]) begin
            regs_d.c[C_PER] = 1'b1;
            regs_d.c[C_ANY] = 1'b1;
        end
        if (ev_alm && regs_q.b[B_ALM_EN]) begin
            regs_d.c[C_ALM] = 1'b1;
            regs_d.c[C_ANY] = 1'b1;
        end
        if (ev_upd && regs_q.b[B_UPD_EN]) begin
            regs_d.c[C_UPD] = 1'b1;
            regs_d.c[C_ANY] = 1'b1;
        end

        if (sys_reset) begin
            regs_d.b[B_PER_EN] = 1'b0;
            regs_d.b[B_ALM_EN] = 1'b0;
            regs_d.b[B_SQW_EN] = 1'b0;
            regs_d.c           = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{a: RST_A, b: RST_B, c: RST_C, d: RST_D};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign regs = regs_q;
    assign irq  = regs_q.c[C_ANY];
endmodule

// File: rtl/rtc_regfile_port.sv
module rtc_regfile_port
    import rtcp_pkg::*;
#(
    parameter int DEPTH = 128,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sys_reset,
    input  logic              host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [BYTE_W-1:0] host_wdata,
    output logic [BYTE_W-1:0] host_rdata,
    input  logic              tk_uip_set,
    input  logic              tk_uip_clr,
    input  logic              ev_periodic,
    input  logic              ev_alarm,
    input  logic              ev_update,
    output logic [BYTE_W-1:0] ctrl_a_o,
    output logic [BYTE_W-1:0] ctrl_b_o,
    output logic              tk_load_o,
    output logic [IDX_W-1:0]  tk_idx_o,
    output logic [BYTE_W-1:0] tk_data_o,
    output logic              irq_o
);
    typedef struct packed {
        logic [IDX_W-1:0]  idx;
        logic [BYTE_W-1:0] rdata;
        logic              tk_load;
        logic [IDX_W-1:0]  tk_idx;
        logic [BYTE_W-1:0] tk_data;
    } port_st_t;

    port_st_t st_d, st_q;

    logic              wr_index, wr_data, rd_data;
    logic              sel_ctrl;
    logic              ctrl_wr, store_wr, rd_c;
    ctrl_sel_e         ctrl_sel;
    ctrl_regs_t        ctrl_regs;
    logic              ctrl_irq;
    logic [BYTE_W-1:0] store_byte;
    logic [BYTE_W-1:0] ctrl_byte;

    assign wr_index = host_wr && !host_addr;
    assign wr_data  = host_wr && host_addr;
    assign rd_data  = host_rd && host_addr;
    assign sel_ctrl = is_ctrl_idx(int'(st_q.idx));
    assign ctrl_wr  = wr_data && sel_ctrl;
    assign store_wr = wr_data && !sel_ctrl;
    assign rd_c     = rd_data && (st_q.idx == IDX_W'(IDX_C));

    always_comb begin
        unique case (int'(st_q.idx))
            IDX_A:   ctrl_sel = SEL_A;
            IDX_B:   ctrl_sel = SEL_B;
            IDX_C:   ctrl_sel = SEL_C;
            default: ctrl_sel = SEL_D;
        endcase
    end

    always_comb begin
        unique case (ctrl_sel)
            SEL_A:   ctrl_byte = ctrl_regs.a;
            SEL_B:   ctrl_byte = ctrl_regs.b;
            SEL_C:   ctrl_byte = ctrl_regs.c;
            default: ctrl_byte = ctrl_regs.d;
        endcase
    end

    rtcp_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_wr),
        .wr_idx  (st_q.idx),
        .wdata   (host_wdata),
        .rd_idx  (st_q.idx),
        .rd_byte (store_byte)
    );

    rtcp_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sys_reset (sys_reset),
        .wr_en     (ctrl_wr),
        .wr_sel    (ctrl_sel),
        .wdata     (host_wdata),
        .rd_c      (rd_c),
        .uip_set   (tk_uip_set),
        .uip_clr   (tk_uip_clr),
        .ev_per    (ev_periodic),
        .ev_alm    (ev_alarm),
        .ev_upd    (ev_update),
        .regs      (ctrl_regs),
        .irq       (ctrl_irq)
    );

    always_comb begin
        st_d         = st_q;
        st_d.tk_load = 1'b0;

        if (wr_index) begin
            st_d.idx = host_wdata[IDX_W-1:0];
        end

        if (host_rd) begin
            if (!host_addr) begin
                st_d.rdata = '1;
            end else if (sel_ctrl) begin
                st_d.rdata = ctrl_byte;
            end else begin
                st_d.rdata = store_byte;
            end
        end

        if (wr_data && is_time_idx(int'(st_q.idx)) && !ctrl_regs.b[B_HALT]) begin
            st_d.tk_load = 1'b1;
            st_d.tk_idx  = st_q.idx;
            st_d.tk_data = host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign host_rdata = st_q.rdata;
    assign ctrl_a_o   = ctrl_regs.a;
    assign ctrl_b_o   = ctrl_regs.b;
    assign tk_load_o  = st_q.tk_load;
    assign tk_idx_o   = st_q.tk_idx;
    assign tk_data_o  = st_q.tk_data;
    assign irq_o      = ctrl_irq;
endmodule

// File: rtl/rtc_regfile_port_chk.sv
module rtc_regfile_port_chk #(
    parameter int IDX_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             sys_reset,
    input logic             host_addr,
    input logic             host_wr,
    input logic             host_rd,
    input logic [7:0]       host_wdata,
    input logic [7:0]       host_rdata,
    input logic             tk_uip_set,
    input logic             tk_uip_clr,
    input logic             ev_periodic,
    input logic             ev_alarm,
    input logic             ev_update,
    input logic [7:0]       ctrl_a_o,
    input logic [7:0]       ctrl_b_o,
    input logic             tk_load_o,
    input logic             irq_o,
    input logic [IDX_W-1:0] idx_q
);
    logic any_ev;
    assign any_ev = ev_periodic || ev_alarm || ev_update;

    assert_even_read_ff_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && !host_addr |=> host_rdata == 8'hFF);

    assert_busy_host_ro_R3: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr && idx_q == IDX_W'(10) && !tk_uip_set && !tk_uip_clr
        |=> ctrl_a_o[7] == $past(ctrl_a_o[7]));

    assert_halt_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        host_wr && host_addr && idx_q == IDX_W'(11) && host_wdata[7] && !tk_uip_set
        |=> !ctrl_a_o[7] && !ctrl_b_o[4]);

    assert_irq_from_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> $past(any_ev));

    assert_status_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        host_rd && host_addr && idx_q == IDX_W'(12) && !any_ev |=> !irq_o);

    assert_soft_reset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset |=> !irq_o && ctrl_b_o[6:5] == 2'b00 && !ctrl_b_o[3]);

    assert_load_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tk_load_o |-> $past(host_wr && host_addr && !ctrl_b_o[7]));
endmodule

bind rtc_regfile_port rtc_regfile_port_chk #(.IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sys_reset   (sys_reset),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_rd     (host_rd),
    .host_wdata  (host_wdata),
    .host_rdata  (host_rdata),
    .tk_uip_set  (tk_uip_set),
    .tk_uip_clr  (tk_uip_clr),
    .ev_periodic (ev_periodic),
    .ev_alarm    (ev_alarm),
    .ev_update   (ev_update),
    .ctrl_a_o    (ctrl_a_o),
    .ctrl_b_o    (ctrl_b_o),
    .tk_load_o   (tk_load_o),
    .irq_o       (irq_o),
    .idx_q       (st_q.idx)
);

// File: tb/rtc_regfile_port_tb.sv
module rtc_regfile_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sys_reset = 1'b0;
    logic       host_addr = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       tk_uip_set = 1'b0;
    logic       tk_uip_clr = 1'b0;
    logic       ev_periodic = 1'b0;
    logic       ev_alarm = 1'b0;
    logic       ev_update = 1'b0;
    logic [7:0] ctrl_a_o, ctrl_b_o, tk_data_o;
    logic [6:0] tk_idx_o;
    logic       tk_load_o, irq_o;

    int tests = 0;
    int fails = 0;

    always #2 clk = ~clk;

    rtc_regfile_port dut_i (
        .clk(clk), .rst_n(rst_n), .sys_reset(sys_reset),
        .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .tk_uip_set(tk_uip_set), .tk_uip_clr(tk_uip_clr),
        .ev_periodic(ev_periodic), .ev_alarm(ev_alarm), .ev_update(ev_update),
        .ctrl_a_o(ctrl_a_o), .ctrl_b_o(ctrl_b_o),
        .tk_load_o(tk_load_o), .tk_idx_o(tk_idx_o), .tk_data_o(tk_data_o),
        .irq_o(irq_o)
    );

    // entry: {addr, wr, rd, data, expected}; only reads are checked
    localparam int NV = 23;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b1, 1'b0, 8'h14, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h5A, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h5A},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hFF},
        {1'b0, 1'b1, 1'b0, 8'h95, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'hC3, 8'h00},
        {1'b0, 1'b1, 1'b0, 8'h14, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h5A},
        {1'b0, 1'b1, 1'b0, 8'h15, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'hC3},
        {1'b0, 1'b1, 1'b0, 8'h0A, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h26},
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h7F},
        {1'b0, 1'b1, 1'b0, 8'h0B, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h02},
        {1'b0, 1'b1, 1'b0, 8'h0D, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'h00, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h80},
        {1'b0, 1'b1, 1'b0, 8'h0C, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'hFF, 8'h00},
        {1'b1, 1'b0, 1'b1, 8'h00, 8'h00},
        {1'b0, 1'b0, 1'b1, 8'h00, 8'hFF}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_wr = 1'b1; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic a, output logic [7:0] d);
        @(negedge clk);
        host_addr = a; host_rd = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic reg_write(input logic [7:0] idx, input logic [7:0] d);
        host_write(1'b0, idx);
        host_write(1'b1, d);
    endtask

    task automatic reg_read(input logic [7:0] idx, output logic [7:0] d);
        host_write(1'b0, idx);
        host_read(1'b1, d);
    endtask

    task automatic pulse(input logic per, input logic alm, input logic upd,
                         input logic uset, input logic uclr, input logic srst);
        @(negedge clk);
        ev_periodic = per; ev_alarm = alm; ev_update = upd;
        tk_uip_set = uset; tk_uip_clr = uclr; sys_reset = srst;
        @(posedge clk); #1;
        ev_periodic = 1'b0; ev_alarm = 1'b0; ev_update = 1'b0;
        tk_uip_set = 1'b0; tk_uip_clr = 1'b0; sys_reset = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] got;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R8 reset state, R11 export buses
        check("R8 A", ctrl_a_o, 8'h26);
        check("R11 B export", ctrl_b_o, 8'h02);
        check("R8 irq", {7'd0, irq_o}, 8'h00);
        check("R8 load", {7'd0, tk_load_o}, 8'h00);
        reg_read(8'd13, got);
        check("R8 D", got, 8'h80);

        // vector walk: R1 index/even read, R2 storage, R3 A bits, R5 C/D
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][17]) begin
                host_write(VEC[i][18], VEC[i][15:8]);
            end else begin
                host_read(VEC[i][18], got);
                check($sformatf("R1/R2/R3/R5 vec %0d", i), got, VEC[i][7:0]);
            end
        end

        // R3 busy flag
        reg_write(8'd10, 8'h26);
        pulse(0, 0, 0, 1, 0, 0);
        check("R3 busy set", ctrl_a_o, 8'hA6);
        host_write(1'b1, 8'h00);
        check("R3 busy kept on write", ctrl_a_o, 8'h80);
        pulse(0, 0, 0, 1, 1, 0);
        check("R3 clear wins", ctrl_a_o, 8'h00);
        host_write(1'b1, 8'h26);
        pulse(0, 0, 0, 1, 0, 0);

        // R4 halt write
        reg_write(8'd11, 8'h92);
        check("R4 busy cleared", ctrl_a_o, 8'h26);
        check("R4 update enable forced", ctrl_b_o, 8'h82);
        pulse(0, 0, 0, 1, 0, 0);
        check("R3 set blocked by halt", ctrl_a_o, 8'h26);

        // R10 time load strobe
        reg_write(8'd0, 8'h33);
        check("R10 no load while halted", {7'd0, tk_load_o}, 8'h00);
        reg_write(8'd11, 8'h02);
        reg_write(8'd0, 8'h45);
        check("R10 load pulse", {7'd0, tk_load_o}, 8'h01);
        check("R10 load idx", {1'b0, tk_idx_o}, 8'h00);
        check("R10 load data", tk_data_o, 8'h45);
        @(posedge clk); #1;
        check("R10 one cycle", {7'd0, tk_load_o}, 8'h00);
        host_read(1'b1, got);
        check("R2 time byte stored", got, 8'h45);
        reg_write(8'd1, 8'h12);
        check("R10 alarm byte no load", {7'd0, tk_load_o}, 8'h00);
        reg_write(8'd9, 8'h99);
        check("R10 year load", {1'b0, tk_idx_o}, 8'h09);

        // R6 enables gate flags
        pulse(1, 1, 1, 0, 0, 0);
        check("R6 disabled no irq", {7'd0, irq_o}, 8'h00);
        reg_read(8'd12, got);
        check("R6 disabled no flag", got, 8'h00);
        reg_write(8'd11, 8'h72);
        pulse(1, 0, 0, 0, 0, 0);
        check("R6 periodic irq", {7'd0, irq_o}, 8'h01);
        reg_read(8'd12, got);
        check("R7 read value", got, 8'hC0);
        check("R7 irq lowered", {7'd0, irq_o}, 8'h00);
        host_read(1'b1, got);
        check("R7 cleared", got, 8'h00);
        pulse(0, 1, 1, 0, 0, 0);
        // R7 read and event in the same cycle
        @(negedge clk);
        host_addr = 1'b1; host_rd = 1'b1; ev_periodic = 1'b1;
        @(posedge clk); #1;
        host_rd = 1'b0; ev_periodic = 1'b0;
        check("R7 concurrent read value", host_rdata, 8'hB0);
        check("R7 concurrent event kept", {7'd0, irq_o}, 8'h01);
        host_read(1'b1, got);
        check("R7 surviving flag", got, 8'hC0);

        // R9 soft reset
        reg_write(8'd11, 8'h7E);
        pulse(0, 0, 1, 0, 0, 0);
        check("R9 irq before", {7'd0, irq_o}, 8'h01);
        pulse(0, 0, 0, 0, 0, 1);
        check("R9 irq", {7'd0, irq_o}, 8'h00);
        check("R9 B", ctrl_b_o, 8'h16);
        check("R9 A kept", ctrl_a_o, 8'h26);
        reg_read(8'd20, got);
        check("R9 store kept", got, 8'h5A);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule